// File: doc/BRIEF.md
# Phase-Error Lock Qualifier

This block decides whether a phase-locked loop is locked by watching the error pulses that its phase detector produces. A fast sampling clock measures the width of each comparison cycle's error as a count of ticks. That count is the time during which either the advance or the retard pulse is high. A strobe marks the end of each comparison cycle. On that strobe the measured width is compared with a threshold that the user sets at run time. The cycle is then classed as good or bad.

The lock indication switches asymmetrically. It is raised only after a run of eight consecutive good cycles, and it is dropped by the first bad one. A timeout watches the spacing of the strobes. If the reference stops, the timeout produces bad cycles of its own, so the indication falls even when no comparisons arrive at all. A loop that drifts out of its pull range, or a reference that jumps in phase, widens the error pulses past the threshold and drops lock through the normal comparison.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst_n_i` is low, and after it is released, `lock_o` is low and the run of good cycles is empty. Reset takes effect without a clock edge. Its release passes through a two-stage synchroniser.
- R2: A cycle's error width is the number of clock edges since the previous cycle end at which `up_i` or `dn_i` is sampled high. The sample taken on the strobe edge itself counts towards the next cycle.
- R3: A cycle that ends with a strobe is good when its width is less than or equal to `thresh_i`, and bad otherwise. `thresh_i` may be changed at run time.
- R4: `lock_o` rises at the clock edge that samples the strobe of the eighth consecutive good cycle, and not earlier.
- R5: A single bad cycle clears `lock_o` at the edge that ends that cycle. It also empties the run, so that eight new good cycles are needed to lock again.
- R6: A tick counter restarts at every cycle end. At an edge without a strobe where the counter is at least `tmo_i`, a bad cycle is produced, which is `tmo_i`+1 edges after the last cycle end. A stopped reference therefore drops lock.
- R7: When a strobe falls on the same edge at which the timeout would expire, the cycle is judged by its width alone and no timeout cycle is produced.
- R8: The width count saturates at 2^WIDTH_W-1 and does not wrap. A long error pulse therefore stays wider than any threshold below the maximum.
- R9: While good cycles continue, `lock_o` stays high. Edges that carry neither a strobe nor a timeout leave the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Advance error pulse from the phase detector |
| dn_i | input | 1 | Retard error pulse from the phase detector |
| strobe_i | input | 1 | One-tick end-of-comparison-cycle marker |
| thresh_i | input | WIDTH_W | Largest error width, in ticks, that still counts as good |
| tmo_i | input | TMO_W | Edge count without a strobe after which a bad cycle is forced |
| lock_o | output | 1 | Lock indication |

## Verification
The comparison strobe and the timeout expiry can land on the same clock edge, and the two give conflicting verdicts. The bench provokes this by spacing strobes exactly `tmo_i`+1 edges apart while the loop is locked. A correct block keeps `lock_o` high, because the in-threshold width wins. It also spaces strobes one edge further apart, which lets the timeout fire first. The bench then expects lock to drop on that edge and the following strobe to start a fresh run.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Verdict handed from the cycle judge to the run qualifier
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } cyc_ev_e;

endpackage

// File: rtl/err_width_meter.sv
module err_width_meter #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               err_i,
  input  logic               clear_i,
  output logic [WIDTH_W-1:0] width_o
);

  localparam logic [WIDTH_W-1:0] W_MAX = {WIDTH_W{1'b1}};

  logic [WIDTH_W-1:0] w_q, w_d;
  logic               w_en;

  always_comb begin
    w_en = clear_i || (err_i && (w_q != W_MAX));
    if (clear_i) begin
      w_d = err_i ? WIDTH_W'(1) : '0;
    end else begin
      w_d = w_q + WIDTH_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      w_q <= '0;
    end else if (w_en) begin
      w_q <= w_d;
    end
  end

  assign width_o = w_q;

  // R8
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (w_q == W_MAX && !clear_i) |=> (w_q == W_MAX));

  // R2
  width_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!clear_i && !err_i) |=> $stable(w_q));

endmodule

// File: rtl/ref_timeout.sv
module ref_timeout #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             strobe_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  localparam logic [TMO_W-1:0] T_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] t_q, t_d;
  logic             t_en;
  logic             expire;

  always_comb begin
    expire = !strobe_i && (t_q >= limit_i);
    t_en   = strobe_i || expire || (t_q != T_MAX);
    t_d    = (strobe_i || expire) ? '0 : (t_q + TMO_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      t_q <= '0;
    end else if (t_en) begin
      t_q <= t_d;
    end
  end

  assign expire_o = expire;

  // R6
  no_early_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strobe_i && limit_i != '0 && $stable(limit_i)) |=> (!expire_o || limit_i == '0 || !$stable(limit_i)));

endmodule

// File: rtl/run_qualifier.sv
module run_qualifier
  import lockdet_pkg::*;
#(
  parameter int GOOD_RUN = 8
) (
  input  logic    clk_i,
  input  logic    rst_n_i,
  input  cyc_ev_e ev_i,
  output logic    lock_o
);

  localparam int CW = $clog2(GOOD_RUN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(GOOD_RUN);
  localparam logic [CW-1:0] RUN_LAST = CW'(GOOD_RUN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          upd_en;

  always_comb begin
    upd_en = (ev_i != EV_NONE);
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (ev_i == EV_GOOD) begin
      cnt_d  = (cnt_q == RUN_FULL) ? cnt_q : (cnt_q + CW'(1));
      lock_d = lock_q || (cnt_q == RUN_LAST);
    end else if (ev_i == EV_BAD) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  // R4
  lock_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    lock_q |-> (cnt_q == RUN_FULL));

  // R4
  rise_on_last_good_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(lock_q) |-> ($past(ev_i) == EV_GOOD && $past(cnt_q) == RUN_LAST));

  // R5
  bad_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ev_i == EV_BAD) |=> (!lock_q && cnt_q == '0));

  // R9
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ev_i == EV_NONE) |=> ($stable(lock_q) && $stable(cnt_q)));

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int WIDTH_W  = 8,
  parameter int TMO_W    = 16,
  parameter int GOOD_RUN = 8
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               up_i,
  input  logic               dn_i,
  input  logic               strobe_i,
  input  logic [WIDTH_W-1:0] thresh_i,
  input  logic [TMO_W-1:0]   tmo_i,
  output logic               lock_o
);

  // R1: asynchronous assertion, synchronised release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  logic               err;
  logic               expire;
  logic               cyc_end;
  logic [WIDTH_W-1:0] width;
  cyc_ev_e            ev;

  assign err     = up_i || dn_i;
  assign cyc_end = strobe_i || expire;

  err_width_meter #(.WIDTH_W(WIDTH_W)) u_meter (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .err_i   (err),
    .clear_i (cyc_end),
    .width_o (width)
  );

  ref_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .strobe_i (strobe_i),
    .limit_i  (tmo_i),
    .expire_o (expire)
  );

  // Cycle judge: a strobe outranks a simultaneous timeout (R7)
  always_comb begin
    if (strobe_i) begin
      ev = (width <= thresh_i) ? EV_GOOD : EV_BAD;
    end else if (expire) begin
      ev = EV_BAD;
    end else begin
      ev = EV_NONE;
    end
  end

  run_qualifier #(.GOOD_RUN(GOOD_RUN)) u_qual (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .ev_i    (ev),
    .lock_o  (lock_o)
  );

  // R3
  over_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (strobe_i && width > thresh_i) |=> !lock_o);

  // R7
  strobe_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (strobe_i && width <= thresh_i && lock_o) |=> lock_o);

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_n |-> !lock_o);

endmodule

// File: tb/sim_phase_lock_monitor.sv
module sim_phase_lock_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_W = 8;
  localparam int TMO_W = 16;
  localparam int NV = 26;
  // per vector: UP ticks, DN ticks, expected lock after the cycle
  localparam int VA[NV] = '{3,0,5,2,0,5,1, 6, 4,0,2,5,3,1,0, 5,0, 0, 1,2,3,4,5,0,1,2};
  localparam int VB[NV] = '{0,4,2,5,0,5,3, 0, 4,5,1,0,3,0,0, 0,0, 6, 0,2,5,1,0,0,3,2};
  localparam bit VE[NV] = '{0,0,0,0,0,0,0, 0, 0,0,0,0,0,0,0, 1,1, 0, 0,0,0,0,0,0,0,1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, stb = 1'b0;
  logic [WIDTH_W-1:0] thr = 8'd5;
  logic [TMO_W-1:0]   tmo = 16'd50;
  logic lock;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_lock_monitor u0 (
    .clk_i(clk), .rst_n_i(rst_n), .up_i(up), .dn_i(dn), .strobe_i(stb),
    .thresh_i(thr), .tmo_i(tmo), .lock_o(lock)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s lock_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe p edges after start; UP high for ticks 1..a, DN for 1..b.
  task automatic run_cycle(int a, int b, int p);
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      up  = (k >= 1 && k <= a);
      dn  = (k >= 1 && k <= b);
      stb = (k == p - 1);
    end
    @(negedge clk);
    up = 1'b0; dn = 1'b0; stb = 1'b0;
  endtask

  task automatic relock(string req);
    for (int i = 0; i < 8; i++) run_cycle(1, 0, 12);
    chk(req, lock, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", lock, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", lock, 1'b0);

    // R2 R3 R4 R5 R9: table walk, 7 good / 1 bad / 8 good patterns
    for (int v = 0; v < NV; v++) begin
      run_cycle(VA[v], VB[v], 12);
      chk($sformatf("R4/R5 vector %0d", v), lock, VE[v]);
    end

    // R3: threshold boundary, changed at run time
    thr = 8'd3;
    run_cycle(3, 2, 12);
    chk("R3 width equal to threshold", lock, 1'b1);
    run_cycle(0, 4, 12);
    chk("R3 width one above threshold", lock, 1'b0);
    thr = 8'd5;

    // R6: stopped reference
    relock("R5 relock after bad");
    repeat (50) @(negedge clk);
    chk("R6 before expiry", lock, 1'b1);
    repeat (2) @(negedge clk);
    chk("R6 stopped reference", lock, 1'b0);

    // R7: strobe coincides with expiry edge, width wins
    relock("R4 relock");
    run_cycle(2, 0, 50);
    chk("R7 strobe on expiry edge", lock, 1'b1);
    run_cycle(2, 0, 51);
    chk("R6 expiry one edge before strobe", lock, 1'b0);
    for (int i = 0; i < 7; i++) run_cycle(1, 1, 12);
    chk("R5 run restarted by strobe after expiry", lock, 1'b1);

    // R8: saturation
    tmo = 16'd400;
    thr = 8'd100;
    relock("R4 relock wide timeout");
    run_cycle(290, 0, 300);
    chk("R8 long pulse saturates above threshold", lock, 1'b0);
    thr = 8'd255;
    relock("R4 relock max threshold");
    run_cycle(290, 0, 300);
    chk("R8 saturated width equals max threshold", lock, 1'b1);

    // R1: asynchronous reset in the middle of lock
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears lock", lock, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    thr = 8'd5;
    for (int i = 0; i < 7; i++) run_cycle(1, 0, 12);
    chk("R1 run empty after reset", lock, 1'b0);

    finish_run();
  end

endmodule